// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single write requests into correctly timed write cycles on a byte-wide asynchronous static RAM. The RAM has 17 address bits, a chip-select pair of opposite polarity (one active low, one active high), an active-low write strobe, an active-low read (output) enable and a data bus. The sequencer drives that bus through a data word and an enable, and the pad ring builds the tristate buffer from them. A request carries an address, a data byte and two mode bits. The sequencer accepts it only while idle, runs one write cycle and then returns one acknowledge pulse.

Every interval of the cycle is a parameter counted in system clocks: address setup, minimum write pulse, data setup, data hold, write recovery, output turn-off and whole cycle length. One mode bit chooses which edge ends the write. In strobe-ended mode the selects frame the whole cycle and the write strobe pulses inside them. In select-ended mode the selects assert in the same clock as the strobe falls and release before it. The other mode bit keeps the RAM's output enable low during the cycle. In strobe-ended mode this lengthens the write pulse by the output turn-off time, and the data driver stays off for that window. All RAM pins come straight from flip-flops.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset and whenever no write is in progress, the low-active select and write strobe are high, the high-active select is low, output enable is high, the data driver is off and `req_ready` is 1. The acknowledge cycle already shows these idle values.
- R2: A request is taken only while `req_ready` is 1. A `req_valid` raised during a busy cycle has no effect: it starts no second write and does not reach the address pins. `req_ready` is 0 for every clock of the cycle.
- R3: The address pins show the accepted address whenever any select, the strobe or the driver is active, and they never change while both selects and the strobe are all asserted. In strobe-ended mode the selects assert in the first clock after acceptance, and the strobe falls T_AS clocks later.
- R4: In strobe-ended mode the overlap of both selects with the low strobe lasts max(T_WP, T_DW) clocks when `req_keep_oe`=0. It lasts max(T_WP, T_WHZ+T_DW) clocks when `req_keep_oe`=1.
- R5: The driver presents the accepted byte during the overlap, from the first overlap clock through the last. With `req_keep_oe`=1 in strobe-ended mode, it stays off for the first T_WHZ overlap clocks, which leaves exactly the data setup count. The byte captured by the RAM equals the request data.
- R6: After the overlap ends, the driver keeps the byte for exactly T_DH clocks.
- R7: The cycle length L equals T_AS + overlap + max(T_WR, T_DH, T_WC − T_AS − overlap) clocks, so it is never shorter than T_WC.
- R8: In select-ended mode (`req_cs_mode`=1), the selects assert in the same clock as the strobe falls, T_AS clocks after acceptance. They stay active for max(T_WP, T_DW) clocks whatever `req_keep_oe` is. They release before the strobe, and the strobe stays low until the cycle ends.
- R9: `wr_ack` is high for exactly one clock, L+1 clocks after the accepting edge.
- R10: Output enable is low only when `req_keep_oe`=1, and then for the address-setup and pulse phases (T_AS + overlap clocks). The driver is never on while the RAM could be driving: output enable low, both selects active and the strobe high.
- R11: Address and data are captured at acceptance. Later changes on `req_addr` and `req_data` do not reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | High while idle; a request is taken on a clock with both high |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_cs_mode | input | 1 | 0: strobe ends the write, 1: selects end it |
| req_keep_oe | input | 1 | Hold RAM output enable low during the cycle |
| wr_ack | output | 1 | One-clock pulse at the end of recovery |
| ram_addr | output | ADDR_W | RAM address |
| ram_cs1_n | output | 1 | Low-active chip select |
| ram_cs2 | output | 1 | High-active chip select |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | DATA_W | Data to the bus driver |
| ram_dq_en | output | 1 | Bus driver enable |

## Verification
The bench builds the block with T_AS=2, T_WP=3, T_DW=2, T_DH=2, T_WR=1, T_WHZ=3 and T_WC=10. With these values T_WHZ+T_DW exceeds T_WP, so keeping output enable low visibly lengthens the pulse from 3 to 5 clocks. T_DH also exceeds T_WR, and T_WC is larger than the sum of the minimum intervals. As a result the fill-to-cycle-length branch of the recovery count is exercised, with a different value in the plain case (5) and the stretched case (3). All four combinations of end mode and output-enable handling run, along with a request raised in the middle of a busy cycle.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ASU   = 2'd1,
    ST_PULSE = 2'd2,
    ST_RECOV = 2'd3
  } wr_state_t;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic rd_n;
    logic den;
  } pin_t;

  localparam pin_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1, den: 1'b0};

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);

  always_comb begin
    if (restart)
      cnt_d = '0;
    else if (cnt_q != {W{1'b1}})
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_wr_pkg::*;
#(
  parameter int W     = 6,
  parameter int T_WHZ = 2,
  parameter int T_DH  = 1
) (
  input  wr_state_t    st,
  input  logic [W-1:0] idx,
  input  logic         cs_mode,
  input  logic         keep_oe,
  input  logic         stretch,
  output pin_t         pins
);

  localparam logic [W-1:0] L_WHZ = W'(T_WHZ);
  localparam logic [W-1:0] L_DH  = W'(T_DH);

  always_comb begin
    pins = PINS_IDLE;
    case (st)
      ST_ASU: begin
        pins.sel_n = cs_mode;
        pins.sel   = ~cs_mode;
        pins.rd_n  = ~keep_oe;
      end
      ST_PULSE: begin
        pins.sel_n = 1'b0;
        pins.sel   = 1'b1;
        pins.wr_n  = 1'b0;
        pins.rd_n  = ~keep_oe;
        pins.den   = stretch ? (idx >= L_WHZ) : 1'b1;
      end
      ST_RECOV: begin
        pins.sel_n = cs_mode;
        pins.sel   = ~cs_mode;
        pins.wr_n  = ~cs_mode;
        pins.den   = (idx < L_DH);
      end
      default: pins = PINS_IDLE;
    endcase
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int T_AS   = 2,
  parameter int T_WP   = 3,
  parameter int T_DW   = 2,
  parameter int T_DH   = 1,
  parameter int T_WR   = 2,
  parameter int T_WHZ  = 2,
  parameter int T_WC   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_cs_mode,
  input  logic              req_keep_oe,
  output logic              wr_ack,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs1_n,
  output logic              ram_cs2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_en
);

  localparam int LEN_W    = CNT_W + 2;
  localparam int P_PLAIN  = (T_WP > T_DW) ? T_WP : T_DW;
  localparam int P_STR    = (T_WP > T_WHZ + T_DW) ? T_WP : (T_WHZ + T_DW);
  localparam int R_MIN    = (T_WR > T_DH) ? T_WR : T_DH;
  localparam int F_PLAIN  = T_WC - T_AS - P_PLAIN;
  localparam int F_STR    = T_WC - T_AS - P_STR;
  localparam int R_PLAIN  = (F_PLAIN > R_MIN) ? F_PLAIN : R_MIN;
  localparam int R_STR    = (F_STR > R_MIN) ? F_STR : R_MIN;

  localparam logic [LEN_W-1:0] L_AS      = LEN_W'(T_AS);
  localparam logic [LEN_W-1:0] L_P_PLAIN = LEN_W'(P_PLAIN);
  localparam logic [LEN_W-1:0] L_P_STR   = LEN_W'(P_STR);
  localparam logic [LEN_W-1:0] L_R_PLAIN = LEN_W'(R_PLAIN);
  localparam logic [LEN_W-1:0] L_R_STR   = LEN_W'(R_STR);

  wr_state_t         state_q, st_d;
  logic [LEN_W-1:0]  el_q, el_d, cur_len;
  logic              csm_q, csm_d, keep_q, keep_d, stretch_q, stretch_d;
  logic              accept, last;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_q;
  pin_t              pins_q, pins_d;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign csm_d     = accept ? req_cs_mode : csm_q;
  assign keep_d    = accept ? req_keep_oe : keep_q;
  assign stretch_d = keep_d & ~csm_d;

  always_comb begin
    case (state_q)
      ST_ASU:   cur_len = L_AS;
      ST_PULSE: cur_len = stretch_q ? L_P_STR : L_P_PLAIN;
      ST_RECOV: cur_len = stretch_q ? L_R_STR : L_R_PLAIN;
      default:  cur_len = LEN_W'(1);
    endcase
  end

  assign last = (el_q == cur_len - 1'b1);

  always_comb begin
    st_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) st_d = ST_ASU;
      ST_ASU:   if (last)   st_d = ST_PULSE;
      ST_PULSE: if (last)   st_d = ST_RECOV;
      ST_RECOV: if (last)   st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  sram_wr_timer #(.W(LEN_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (st_d != state_q),
    .cnt_q   (el_q),
    .cnt_d   (el_d)
  );

  sram_wr_decode #(.W(LEN_W), .T_WHZ(T_WHZ), .T_DH(T_DH)) decode_i (
    .st      (st_d),
    .idx     (el_d),
    .cs_mode (csm_d),
    .keep_oe (keep_d),
    .stretch (stretch_d),
    .pins    (pins_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      csm_q     <= 1'b0;
      keep_q    <= 1'b0;
      stretch_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      ack_q     <= 1'b0;
      pins_q    <= PINS_IDLE;
    end else begin
      state_q   <= st_d;
      csm_q     <= csm_d;
      keep_q    <= keep_d;
      stretch_q <= stretch_d;
      ack_q     <= (state_q == ST_RECOV) && last;
      pins_q    <= pins_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign wr_ack     = ack_q;
  assign ram_addr   = addr_q;
  assign ram_dq_out = data_q;
  assign ram_cs1_n  = pins_q.sel_n;
  assign ram_cs2    = pins_q.sel;
  assign ram_we_n   = pins_q.wr_n;
  assign ram_oe_n   = pins_q.rd_n;
  assign ram_dq_en  = pins_q.den;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_cs1_n,
  input logic              ram_cs2,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_en
);

  logic cs_act, ovl;
  assign cs_act = !ram_cs1_n && ram_cs2;
  assign ovl    = cs_act && !ram_we_n;

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (ovl && $past(ovl)) |-> $stable(ram_addr));

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
    !(ram_dq_en && !ram_oe_n && cs_act && ram_we_n));

  assert_strobe_selected_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> cs_act);

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);

  assert_idle_at_ack_R1: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> (ram_we_n && ram_cs1_n && !ram_cs2 && !ram_dq_en && ram_oe_n && req_ready));

  assert_hold_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ovl) |-> ram_dq_en);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .wr_ack    (wr_ack),
  .ram_addr  (ram_addr),
  .ram_cs1_n (ram_cs1_n),
  .ram_cs2   (ram_cs2),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_dq_en (ram_dq_en)
);

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;

  localparam int B_AS = 2, B_WP = 3, B_DW = 2, B_DH = 2, B_WR = 1, B_WHZ = 3, B_WC = 10;
  localparam int WIN  = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        req_cs_mode = 1'b0;
  logic        req_keep_oe = 1'b0;
  logic        wr_ack;
  logic [16:0] ram_addr;
  logic        ram_cs1_n, ram_cs2, ram_we_n, ram_oe_n, ram_dq_en;
  logic [7:0]  ram_dq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  sram_wr_seq #(
    .ADDR_W(17), .DATA_W(8), .CNT_W(4),
    .T_AS(B_AS), .T_WP(B_WP), .T_DW(B_DW), .T_DH(B_DH),
    .T_WR(B_WR), .T_WHZ(B_WHZ), .T_WC(B_WC)
  ) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .req_cs_mode(req_cs_mode), .req_keep_oe(req_keep_oe),
    .wr_ack(wr_ack), .ram_addr(ram_addr),
    .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_en(ram_dq_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic test_reset_idle();
    @(negedge clk);
    check("R1", "cs1_n idle", int'(ram_cs1_n), 1);
    check("R1", "cs2 idle", int'(ram_cs2), 0);
    check("R1", "we_n idle", int'(ram_we_n), 1);
    check("R1", "oe_n idle", int'(ram_oe_n), 1);
    check("R1", "driver idle", int'(ram_dq_en), 0);
    check("R1", "ready idle", int'(req_ready), 1);
    check("R9", "no ack idle", int'(wr_ack), 0);
  endtask

  task automatic run_write(input logic csm, input logic keep, input logic [16:0] a,
                           input logic [7:0] d, input logic poke_busy);
    int stretch, plen, rlen, total;
    int first_cs = 0, first_we = 0, first_ovl = 0, first_den = 0, last_ovl = 0;
    int cnt_cs = 0, cnt_we = 0, cnt_ovl = 0, den_ovl = 0, hold = 0, bad_data = 0;
    int oe_low = 0, busy = 0, bad_addr = 0, ack_cnt = 0, ack_idx = 0, late_cs = 0;
    int wbyte = -1;
    logic cs, ovl;
    stretch = (keep && !csm) ? 1 : 0;
    plen    = imax(B_WP, stretch ? (B_WHZ + B_DW) : B_DW);
    rlen    = imax(imax(B_WR, B_DH), B_WC - B_AS - plen);
    total   = B_AS + plen + rlen;

    @(negedge clk);
    check("R2", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    req_cs_mode = csm; req_keep_oe = keep;
    @(posedge clk);
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_valid = 1'b0; req_addr = ~a; req_data = ~d;
        req_cs_mode = ~csm; req_keep_oe = ~keep;
      end
      cs  = !ram_cs1_n && ram_cs2;
      ovl = cs && !ram_we_n;
      if (cs) begin
        cnt_cs++;
        if (first_cs == 0) first_cs = n;
        if (ack_idx != 0) late_cs++;
      end
      if (!ram_we_n) begin
        cnt_we++;
        if (first_we == 0) first_we = n;
      end
      if (ovl) begin
        cnt_ovl++;
        last_ovl = n;
        if (first_ovl == 0) first_ovl = n;
        if (ram_dq_en) begin
          den_ovl++;
          wbyte = int'(ram_dq_out);
          if (first_den == 0) first_den = n;
        end
      end
      if (ram_dq_en && !ovl && last_ovl != 0) hold++;
      if (ram_dq_en && ram_dq_out != d) bad_data++;
      if (!ram_oe_n) oe_low++;
      if (!req_ready) busy++;
      if ((cs || !ram_we_n || ram_dq_en) && ram_addr != a) bad_addr++;
      if (wr_ack) begin
        ack_cnt++;
        if (ack_idx == 0) ack_idx = n;
      end
      if (poke_busy && n == 4) begin req_valid = 1'b1; req_addr = a ^ 17'h155; end
      if (poke_busy && n == 6) req_valid = 1'b0;
    end

    check(csm ? "R8" : "R4", "overlap length", cnt_ovl, plen);
    if (!csm) begin
      check("R3", "selects first clock", first_cs, 1);
      check("R3", "strobe after setup", first_we, B_AS + 1);
      check("R4", "strobe low length", cnt_we, plen);
      check("R4", "selects span cycle", cnt_cs, total);
    end else begin
      check("R8", "selects with strobe", first_cs, first_we);
      check("R8", "strobe after setup", first_we, B_AS + 1);
      check("R8", "select length", cnt_cs, B_WP > B_DW ? B_WP : B_DW);
      check("R8", "strobe to end", cnt_we, plen + rlen);
    end
    check("R5", "driven overlap clocks", den_ovl, stretch ? (plen - B_WHZ) : plen);
    check("R5", "driver off window", first_den - first_ovl, stretch ? B_WHZ : 0);
    check("R5", "driven to last overlap", int'(den_ovl >= B_DW), 1);
    check("R5", "byte written", wbyte, int'(d));
    check("R5", "data mismatches", bad_data, 0);
    check("R6", "hold clocks", hold, B_DH);
    check("R7", "cycle not below T_WC", int'(total >= B_WC), 1);
    check("R9", "ack position", ack_idx, total + 1);
    check("R9", "ack count", ack_cnt, 1);
    check("R10", "oe low clocks", oe_low, keep ? (B_AS + plen) : 0);
    check("R11", "address mismatches", bad_addr, 0);
    check("R2", "busy clocks", busy, total);
    check("R2", "no second write", late_cs, 0);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset_idle();
    run_write(1'b0, 1'b0, 17'h1A5C3, 8'h5A, 1'b0);
    run_write(1'b0, 1'b1, 17'h00F0F, 8'hC3, 1'b0);
    run_write(1'b1, 1'b0, 17'h1FFFF, 8'h81, 1'b0);
    run_write(1'b1, 1'b1, 17'h10001, 8'h3C, 1'b0);
    run_write(1'b0, 1'b0, 17'h0AAAA, 8'hE7, 1'b1);
    test_reset_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule